// File: doc/BRIEF.md
# Leading-One Left Normalizer

This block takes an 11-bit word and slides it toward the top until its highest set bit lands in the most significant position. The word is handled as a raw two's complement bit pattern. A value whose top bit is already 1, which covers every negative value, comes out unchanged. A word of all zeroes comes out as all zeroes. Bits that move in at the bottom are always 0.

The logic is purely combinational. It is a chain of identical stages. Each stage has a fixed one-place shift network made of wiring only, and a word-wide two-way selector. The selector keeps the stage input when that input's top bit is 1, and takes the shifted word when the top bit is 0. Ten stages are enough to carry a lone bit from position 0 up to position 10. A side output reports how many stages shifted. For a nonzero input this equals the number of leading zeros.

Top module: `lz_normalizer`

## Requirements
- R1: For a nonzero input `din`, `dout` equals `din` shifted left by the number of zero bits above its highest set bit, with zeros filling the vacated low positions.
- R2: When `din` is all zeroes, `dout` is all zeroes.
- R3: When `din[10]` is 1, `dout` equals `din` and `shift_cnt` is 0.
- R4: For every nonzero `din`, `dout[10]` is 1.
- R5: When `din` has only bit 0 set, `dout` has only bit 10 set and `shift_cnt` is 10.
- R6: For a nonzero input, `shift_cnt` (unsigned, 4 bits) equals the count of leading zero bits of `din`. For an all-zero input, it is 10, because every stage shifts.
- R7: The lowest `shift_cnt` bits of `dout` are always 0.
- R8: The block holds no state. `dout` and `shift_cnt` depend only on the present `din` and follow a change in `din` without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 11 | Word to normalize (two's complement bit pattern) |
| dout | output | 11 | Normalized word, leading one at bit 10 |
| shift_cnt | output | 4 | Number of stages that shifted |

## Verification
Both results are due in the same cycle in which the input is applied, with zero cycles of latency. The bench drives `din` just after a rising edge of its sampling clock and reads `dout` and `shift_cnt` at the following falling edge, half a period later, so that the combinational paths have settled. No check waits for a clock edge to pass through the block, and each check compares only against the value of `din` applied in the same half period.

// File: rtl/nrm_pkg.sv
package nrm_pkg;
  parameter int NRM_DEF_W = 11;

  function automatic int nrm_cnt_w(input int w);
    return (w <= 2) ? 1 : $clog2(w);
  endfunction
endpackage

// File: rtl/nrm_shl1.sv
module nrm_shl1 #(
  parameter int W = nrm_pkg::NRM_DEF_W
) (
  input  logic [W-2:0] src_low,
  output logic [W-1:0] dst
);
  assign dst = {src_low, 1'b0};
endmodule

// File: rtl/nrm_mux2.sv
module nrm_mux2 #(
  parameter int W = nrm_pkg::NRM_DEF_W
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         sel,
  output logic [W-1:0] res
);
  assign res = ({W{~sel}} & opa) | ({W{sel}} & opb);
endmodule

// File: rtl/nrm_cond_stage.sv
module nrm_cond_stage #(
  parameter int W = nrm_pkg::NRM_DEF_W
) (
  input  logic [W-1:0] stg_in,
  output logic [W-1:0] stg_out,
  output logic         stg_shifted
);
  logic [W-1:0] shifted_w;

  nrm_shl1 #(.W(W)) u_shl (
    .src_low (stg_in[W-2:0]),
    .dst     (shifted_w)
  );

  assign stg_shifted = ~stg_in[W-1];

  nrm_mux2 #(.W(W)) u_mux (
    .opa (shifted_w),
    .opb (stg_in),
    .sel (stg_in[W-1]),
    .res (stg_out)
  );

  always_comb begin
    if (stg_in[W-1]) begin
      p_stage_keep_r3: assert (stg_out == stg_in)
        else $error("stage altered a word with top bit set");
    end else begin
      p_stage_move_r1: assert ((stg_out[W-1:1] == stg_in[W-2:0]) && !stg_out[0])
        else $error("stage did not move word up one place");
    end
  end
endmodule

// File: rtl/lz_normalizer.sv
module lz_normalizer #(
  parameter int W = nrm_pkg::NRM_DEF_W
) (
  input  logic [W-1:0]                  din,
  output logic [W-1:0]                  dout,
  output logic [nrm_pkg::nrm_cnt_w(W)-1:0] shift_cnt
);
  localparam int NSTG = W - 1;
  localparam int CW   = nrm_pkg::nrm_cnt_w(W);

  logic [W-1:0] chain [0:NSTG];
  logic [NSTG-1:0] moved;

  assign chain[0] = din;

  generate
    for (genvar g = 0; g < NSTG; g++) begin : g_stage
      nrm_cond_stage #(.W(W)) u_stage (
        .stg_in      (chain[g]),
        .stg_out     (chain[g+1]),
        .stg_shifted (moved[g])
      );
    end
  endgenerate

  assign dout = chain[NSTG];

  always_comb begin
    shift_cnt = '0;
    for (int i = 0; i < NSTG; i++) begin
      shift_cnt = shift_cnt + CW'(moved[i]);
    end
  end

  logic [W-1:0] tail_mask;
  assign tail_mask = ~({W{1'b1}} << shift_cnt);

  always_comb begin
    if (din == '0) begin
      p_zero_out_r2: assert (dout == '0)
        else $error("zero input gave nonzero output");
    end else begin
      p_lead_one_r4: assert (dout[W-1])
        else $error("nonzero input left top bit clear");
      p_shift_match_r1: assert (dout == (din << shift_cnt))
        else $error("output differs from input shifted by count");
    end
    p_tail_clear_r7: assert ((dout & tail_mask) == '0)
      else $error("vacated low bits not zero");
    if (din[W-1]) begin
      p_no_shift_r3: assert (shift_cnt == '0)
        else $error("count nonzero for top-bit-set input");
    end
  end
endmodule

// File: tb/lz_normalizer_bench.sv
module lz_normalizer_bench;
  localparam int W  = 11;
  localparam int CW = 4;

  logic          clk;
  logic [W-1:0]  din;
  logic [W-1:0]  dout;
  logic [CW-1:0] shift_cnt;

  int n_checks;
  int n_errors;
  bit done;

  lz_normalizer #(.W(W)) u_lz_normalizer (
    .din       (din),
    .dout      (dout),
    .shift_cnt (shift_cnt)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int ref_lead_zeros(input logic [W-1:0] v);
    int n;
    n = 0;
    for (int i = W - 1; i >= 0; i--) begin
      if (v[i]) return n;
      n++;
    end
    return W - 1;
  endfunction

  function automatic logic [W-1:0] ref_norm(input logic [W-1:0] v);
    logic [W-1:0] r;
    r = v;
    if (v == '0) return '0;
    while (!r[W-1]) r = {r[W-2:0], 1'b0};
    return r;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s din=%h actual=%h expected=%h", tag, din, got, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] v);
    logic [W-1:0] en;
    int lz;
    @(posedge clk);
    din = v;
    @(negedge clk);
    en = ref_norm(v);
    lz = ref_lead_zeros(v);
    check("R1/R2 dout", dout, en);
    check("R6 shift_cnt", W'(shift_cnt), W'(lz));
    if (v != '0) check("R4 top bit", W'(dout[W-1]), W'(1));
    check("R7 low bits", dout & ~({W{1'b1}} << lz), '0);
  endtask

  initial begin
    logic [W-1:0] prev;
    int seed;
    n_checks = 0;
    n_errors = 0;
    done = 0;
    din = '0;
    @(negedge clk);
    check("R2 zero start", dout, '0);
    check("R6 zero count", W'(shift_cnt), W'(10));

    apply(11'h001);
    check("R5 lsb only", dout, 11'h400);
    check("R5 lsb count", W'(shift_cnt), W'(10));
    apply(11'h400);
    check("R3 msb only", dout, 11'h400);
    apply(11'h7FF);
    check("R3 all ones", dout, 11'h7FF);
    check("R3 all ones count", W'(shift_cnt), W'(0));
    apply(11'h555);
    check("R3 negative pattern", dout, 11'h555);
    apply(11'h3FF);
    check("R1 one leading zero", dout, 11'h7FE);
    apply(11'h000);
    check("R2 zero again", dout, '0);

    // R8: change input mid-cycle, no clock edge in between
    @(negedge clk);
    din = 11'h003;
    #2;
    check("R8 comb response", dout, 11'h600);
    din = 11'h020;
    #2;
    check("R8 comb response 2", dout, 11'h400);
    check("R8 comb count", W'(shift_cnt), W'(5));

    for (int v = 0; v < (1 << W); v++) apply(W'(v));

    seed = 32'h5eed;
    void'($urandom(seed));
    for (int k = 0; k < 300; k++) begin
      prev = W'($urandom);
      if (k % 3 == 0) prev = prev >> ($urandom % W);
      apply(prev);
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule